// File: doc/BRIEF.md
# Cascadable Programmable Tap Delay

This block delays a single-bit data stream by a whole number of clock cycles. The cycle count is picked by a ten-bit binary code, and every tap of that code sits on top of a constant latency. An eleventh select bit, the cascade bit, replaces the code with the full 1024-cycle span. A following stage can read that bit to stretch the total range. The select word passes through a transparent holding stage while the hold input is low, and it keeps its value while the hold input is high.

Two override inputs clear or fill the held select word. Clearing gives the shortest path and filling gives the longest. When both are high, clearing wins. A blanking input drives the registered data output low. A complementary pair of cascade outputs carries the held cascade bit. The pair can drive the overrides of a second instance: the true output goes to its maximum override and the inverted output goes to its minimum override. The second stage then sits at its shortest delay until the first stage runs out of range.

Top module: `prog_tap_delay`

## Requirements
- R1: With the cascade bit (sel_in[10]) clear, a bit sampled on din reaches dout after 2 + N rising edges, counting the sampling edge as the first. N is the code on sel_in[9:0], with bit k weighted 2^k.
- R2: With the cascade bit set, the delay is 2 + 1024 edges whatever sel_in[9:0] holds.
- R3: While len_hold is low, a change on sel_in selects the new tap in the same cycle.
- R4: While len_hold is high, changes on sel_in have no effect. The select value captured at the last edge with len_hold low stays in force.
- R5: While force_min is high, the delay is 2 edges and casc_p is 0. Afterwards the held select word is all zeros until it is loaded again.
- R6: While force_max is high (and force_min low), all eleven select bits read as one, so the delay is 2 + 1024 and casc_p is 1. Afterwards the held word stays all ones until it is loaded again.
- R7: When force_min and force_max are both high, force_min wins.
- R8: When blank is high at an edge, dout is 0 after that edge. When blank is low, dout carries the delayed data.
- R9: casc_p equals the cascade bit of the select word in force, and casc_n is always its inverse.
- R10: After a synchronous reset, dout is 0 and the held select word is zero, so casc_p = 0 and casc_n = 1 while len_hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input to be delayed |
| sel_in | input | 11 | Bits 9:0 are the tap code and bit 10 is the cascade bit |
| len_hold | input | 1 | 0 lets sel_in through; 1 holds the captured select word |
| force_min | input | 1 | Clears the select word (shortest delay); takes priority |
| force_max | input | 1 | Fills the select word with ones (longest delay) |
| blank | input | 1 | Drives dout low at the next edge |
| dout | output | 1 | Delayed, registered data output |
| casc_p | output | 1 | Cascade bit in force |
| casc_n | output | 1 | Inverse of casc_p |

## Verification
The assertions assume that reset lasts at least two edges, that inputs change only away from the rising edge, and that din is held low during reset, so no stale data sits in the line at release. The bench drives every input a short time after each rising edge. It keeps din at 0 and asserts reset for several cycles before releasing it. Random phases draw the code, the hold level, the overrides and blanking with fixed probabilities. Directed phases hold the code at the extremes long enough to drain the full 1026-cycle path.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
    localparam int CODE_W    = 10;
    localparam int SEL_W     = CODE_W + 1;
    localparam int MAX_TAP   = 1 << CODE_W;
    localparam int TAP_IDX_W = CODE_W + 1;

    typedef struct packed {
        logic              casc;
        logic [CODE_W-1:0] code;
    } sel_t;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_MIN  = 2'd1,
        OVR_MAX  = 2'd2
    } ovr_e;

    function automatic ovr_e pick_override(logic fmin, logic fmax);
        if (fmin)      return OVR_MIN;
        else if (fmax) return OVR_MAX;
        else           return OVR_NONE;
    endfunction

    function automatic logic [TAP_IDX_W-1:0] tap_index(sel_t s);
        if (s.casc) return TAP_IDX_W'(MAX_TAP);
        else        return {1'b0, s.code};
    endfunction
endpackage

// File: rtl/ptd_sel_latch.sv
module ptd_sel_latch
    import ptd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel_d,
    input  logic hold,
    input  logic force_min,
    input  logic force_max,
    output sel_t sel_q
);
    sel_t held_q;
    ovr_e ovr;

    always_comb begin
        ovr = pick_override(force_min, force_max);
        unique case (ovr)
            OVR_MIN: sel_q = '0;
            OVR_MAX: sel_q = '1;
            default: sel_q = hold ? held_q : sel_d;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= sel_q;
    end
endmodule

// File: rtl/ptd_tap_line.sv
module ptd_tap_line
    import ptd_pkg::*;
#(
    parameter int FIX_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    input  logic [TAP_IDX_W-1:0] tap_sel,
    output logic                 tap_out
);
    localparam int PRE_N = FIX_LAT - 1;

    logic               pre_q [PRE_N];
    logic [MAX_TAP-1:0] line_q;
    logic [MAX_TAP:0]   ext;

    for (genvar i = 0; i < PRE_N; i++) begin : g_pre
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pre_q[i] <= 1'b0;
                else     pre_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pre_q[i] <= 1'b0;
                else     pre_q[i] <= pre_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[MAX_TAP-2:0], pre_q[PRE_N-1]};
    end

    assign ext     = {line_q, pre_q[PRE_N-1]};
    assign tap_out = ext[tap_sel];
endmodule

// File: rtl/prog_tap_delay.sv
module prog_tap_delay
    import ptd_pkg::*;
#(
    parameter int FIX_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             len_hold,
    input  logic             force_min,
    input  logic             force_max,
    input  logic             blank,
    output logic             dout,
    output logic             casc_p,
    output logic             casc_n
);
    sel_t                 sel_eff;
    logic [TAP_IDX_W-1:0] tap_sel;
    logic                 tap_bit;
    logic                 dout_q;

    ptd_sel_latch i_latch (
        .clk       (clk),
        .rst       (rst),
        .sel_d     (sel_t'(sel_in)),
        .hold      (len_hold),
        .force_min (force_min),
        .force_max (force_max),
        .sel_q     (sel_eff)
    );

    assign tap_sel = tap_index(sel_eff);

    ptd_tap_line #(.FIX_LAT(FIX_LAT)) i_line (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .tap_sel (tap_sel),
        .tap_out (tap_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)        dout_q <= 1'b0;
        else if (blank) dout_q <= 1'b0;
        else            dout_q <= tap_bit;
    end

    assign dout   = dout_q;
    assign casc_p = sel_eff.casc;
    assign casc_n = ~sel_eff.casc;
endmodule

// File: rtl/ptd_checker.sv
module ptd_checker #(
    parameter int FIX_LAT = 2
) (
    input logic clk,
    input logic rst,
    input logic din,
    input logic len_hold,
    input logic force_min,
    input logic force_max,
    input logic blank,
    input logic dout,
    input logic casc_p,
    input logic casc_n
);
    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (rst)
        blank |=> !dout); // R8

    AST_MIN_CASC: assert property (@(posedge clk) disable iff (rst)
        force_min |-> (!casc_p && casc_n)); // R5

    AST_MAX_CASC: assert property (@(posedge clk) disable iff (rst)
        (force_max && !force_min) |-> (casc_p && !casc_n)); // R6

    AST_MIN_WINS: assert property (@(posedge clk) disable iff (rst)
        (force_min && force_max) |-> !casc_p); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (len_hold && $past(len_hold) && !$past(rst) && !force_min && !force_max)
        |-> $stable(casc_p)); // R4

    if (FIX_LAT == 2) begin : g_fixed
        AST_SHORT_PATH: assert property (@(posedge clk) disable iff (rst)
            (warm_q == 2'd3 && $past(force_min) && !$past(blank))
            |-> (dout == $past(din, 2))); // R1
    end
endmodule

bind prog_tap_delay ptd_checker #(.FIX_LAT(FIX_LAT)) i_ptd_checker (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .len_hold  (len_hold),
    .force_min (force_min),
    .force_max (force_max),
    .blank     (blank),
    .dout      (dout),
    .casc_p    (casc_p),
    .casc_n    (casc_n)
);

// File: tb/test_prog_tap_delay.sv
`timescale 1ns/1ps
module test_prog_tap_delay;
    import ptd_pkg::*;

    localparam int HIST_N = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             din = 1'b0;
    logic [SEL_W-1:0] sel_in = '0;
    logic             len_hold = 1'b0;
    logic             force_min = 1'b0;
    logic             force_max = 1'b0;
    logic             blank = 1'b0;
    logic             dout, casc_p, casc_n;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc_n    = 0;
    bit   done     = 1'b0;
    bit   hist [HIST_N];
    sel_t m_hold   = '0;

    always #10 clk = ~clk;

    prog_tap_delay i_prog_tap_delay (
        .clk(clk), .rst(rst), .din(din), .sel_in(sel_in), .len_hold(len_hold),
        .force_min(force_min), .force_max(force_max), .blank(blank),
        .dout(dout), .casc_p(casc_p), .casc_n(casc_n)
    );

    function automatic sel_t model_sel(sel_t h, sel_t d, bit ln, bit mn, bit mx);
        if (mn) return '0;
        if (mx) return '1;
        if (ln) return h;
        return d;
    endfunction

    function automatic int taps_of(sel_t s);
        return s.casc ? 1024 : int'(s.code);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc_n);
        end
    endtask

    // One clock: model the edge, then compare the outputs 2 ns after it.
    task automatic step(string base_tag, string force_tag = "");
        sel_t  e, after;
        int    n;
        bit    exp_d;
        string tag;
        @(posedge clk);
        e      = model_sel(m_hold, sel_t'(sel_in), len_hold, force_min, force_max);
        m_hold = e;
        n      = taps_of(e);
        hist[cyc_n % HIST_N] = din;
        if (blank)              exp_d = 1'b0;
        else if (cyc_n >= n + 1) exp_d = hist[(cyc_n - 1 - n) % HIST_N];
        else                    exp_d = 1'b0;
        if (force_tag != "")              tag = force_tag;
        else if (blank)                   tag = "R8";
        else if (force_min && force_max)  tag = "R7";
        else if (force_min)               tag = "R5";
        else if (force_max)               tag = "R6";
        else if (len_hold)                tag = "R4";
        else if (e.casc)                  tag = "R2";
        else                              tag = base_tag;
        after = model_sel(m_hold, sel_t'(sel_in), len_hold, force_min, force_max);
        cyc_n++;
        #2;
        check(dout == exp_d, tag, "dout", int'(dout), int'(exp_d));
        check(casc_p == after.casc && casc_n == !after.casc, "R9", "casc_p",
              int'(casc_p), int'(after.casc));
    endtask

    task automatic run_fixed(int cycles, logic [SEL_W-1:0] s, bit ln, string tag);
        for (int i = 0; i < cycles; i++) begin
            din = 1'($urandom); sel_in = s; len_hold = ln;
            force_min = 1'b0; force_max = 1'b0; blank = 1'b0;
            step(tag);
        end
    endtask

    initial begin
        int codes [8] = '{0, 1, 2, 3, 37, 64, 512, 1023};
        void'($urandom(32'h5EED));
        len_hold = 1'b1;
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;

        // R10: reset state with the select word held
        step("R10", "R10");
        check(casc_n == 1'b1, "R10", "casc_n", int'(casc_n), 1);

        // R1: directed codes, including both ends of the range
        foreach (codes[k]) run_fixed(codes[k] + 40, 11'(codes[k]), 1'b0, "R1");
        for (int k = 0; k < 3; k++) begin
            int c = int'($urandom % 1024);
            run_fixed(c + 30, 11'(c), 1'b0, "R1");
        end

        // R2: cascade bit with arbitrary low bits
        run_fixed(1100, {1'b1, 10'h000}, 1'b0, "R2");
        run_fixed(1100, {1'b1, 10'h2A5}, 1'b0, "R2");

        // R3 / R4: select changes every cycle, hold toggles
        for (int i = 0; i < 600; i++) begin
            din = 1'($urandom); sel_in = 11'($urandom % 64) | (($urandom % 8 == 0) ? 11'h400 : 11'h0);
            len_hold = ($urandom % 3 == 0);
            step("R3");
        end

        // R6 then hold: all ones stay in force after the pulse
        din = 1'($urandom); len_hold = 1'b1; force_max = 1'b1; step("R6");
        force_max = 1'b0;
        for (int i = 0; i < 1080; i++) begin
            din = 1'($urandom); sel_in = 11'($urandom); step("R6", "R6");
        end
        // R5 then hold: all zeros stay in force after the pulse
        din = 1'($urandom); force_min = 1'b1; force_max = 1'b1; step("R7");
        force_max = 1'b0; step("R5");
        force_min = 1'b0;
        for (int i = 0; i < 60; i++) begin
            din = 1'($urandom); sel_in = 11'($urandom); step("R5", "R5");
        end

        // Random overrides and hold, short codes
        for (int i = 0; i < 1500; i++) begin
            din = 1'($urandom); sel_in = 11'($urandom % 32);
            len_hold  = ($urandom % 2 == 0);
            force_min = ($urandom % 5 == 0);
            force_max = ($urandom % 4 == 0);
            step("R1");
        end
        force_min = 1'b0; force_max = 1'b0;

        // R8: random blanking over a fixed code
        for (int i = 0; i < 400; i++) begin
            din = 1'($urandom); sel_in = 11'd9; len_hold = 1'b0;
            blank = ($urandom % 3 == 0);
            step("R8");
        end
        blank = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule